// File: doc/BRIEF.md
# Shared Cache Power-Up Sequencer

This block is a hardware sequencer that takes a shared second-level cache power domain from off to fully powered. It drives three 32-bit control words: a power-control word, an override word and a clock branch-control word. A one-cycle start pulse begins the sequence. The block then writes a fixed series of values to those words, one write per cycle. Timed waits of a whole number of microseconds separate some of the writes. Each word keeps its last written value until the next write to it.

The start pulse is sampled against a power-status word. When every bit selected by the status mask is already set, the domain counts as up. In that case the block writes nothing and reports done straight away. Wait lengths are counted in clock cycles, as the microsecond figure times the `CYC_PER_US` parameter.

Top module: `l2_pwr_seq`

## Requirements
- R1: While `rst_ni` is low, all three control words read zero and `busy_o` and `done_o` are low.
- R2: A start pulse taken while idle, when the status is not fully up, raises `busy_o` in the next cycle. `busy_o` then stays high until the cycle in which `done_o` is high, when it drops.
- R3: A start pulse taken while idle, when every bit of `status_i` selected by `UP_MASK` is set, gives `done_o` high in the next cycle. `busy_o` stays low and no control word changes.
- R4: The schedule writes, in this order: power word 0x0010D700, override word 0x00400000, power word 0x00101700, power word 0x00101703, clock word 0x00000001, power word 0x00101603, override word 0x00000000, power word 0x00100203, power word 0x10100203, clock word 0x00000003. At most one word changes per cycle.
- R5: The first write appears in the cycle after busy rises. A write that follows a wait of W microseconds appears W*CYC_PER_US+1 cycles after the write before it, and any other write appears in the next cycle. Waits of 2 us follow the 2nd, 4th and 6th writes, and a wait of 54 us follows the 8th write.
- R6: `done_o` is a one-cycle pulse. In a full run it appears in the same cycle that the final clock-word value becomes visible.
- R7: A start pulse that arrives while `busy_o` is high has no effect on the schedule, its timing or the outputs.
- R8: While idle, no control word changes, except through reset.
- R9: Only the status bits selected by `UP_MASK` (bit 9 by default) affect the skip decision. A status with every other bit set and bit 9 clear still runs the full schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, one cycle |
| status_i | input | STAT_W | Power-status word of the cache domain |
| busy_o | output | 1 | Schedule in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pwr_ctl_o | output | 32 | Power-control word |
| ovr_ctl_o | output | 32 | Override word |
| clk_ctl_o | output | 32 | Clock branch-control word |

## Verification
The bench builds the block with `CYC_PER_US` = 3 and the default mask on status bit 9. The longest wait is then 162 cycles, and a full schedule takes 190 cycles, so many complete runs fit the budget. Each run is compared cycle by cycle against a schedule that the bench derives on its own.

A factor of 3 exposes errors in wait scaling, and off-by-one errors in the wait counter, that a factor of 1 would hide. The bench also runs from nonzero words left by earlier runs and mixes in skip cases. It fires stray start pulses during runs and asserts reset part way through a run.

// File: rtl/l2_pwr_seq_pkg.sv
package l2_pwr_seq_pkg;
  localparam int WORD_W      = 32;
  localparam int N_WORDS     = 3;
  localparam int N_STEPS     = 10;
  localparam int IDX_W       = $clog2(N_STEPS);
  localparam int US_W        = 6;
  localparam int MAX_WAIT_US = 54;

  typedef enum logic [1:0] {
    TGT_PWR = 2'd0,
    TGT_OVR = 2'd1,
    TGT_CLK = 2'd2
  } tgt_e;

  typedef struct packed {
    tgt_e              tgt;
    logic [WORD_W-1:0] val;
    logic [US_W-1:0]   wait_us;
  } step_t;

  function automatic step_t mk_step(input tgt_e t, input logic [WORD_W-1:0] v,
                                    input logic [US_W-1:0] w);
    step_t s;
    s.tgt     = t;
    s.val     = v;
    s.wait_us = w;
    return s;
  endfunction

  // ordering is behaviour: clamp release, ram wake, clock on, reset release
  function automatic step_t step_at(input logic [IDX_W-1:0] i);
    case (int'(i))
      0:       return mk_step(TGT_PWR, 32'h0010_D700, 6'd0);
      1:       return mk_step(TGT_OVR, 32'h0040_0000, 6'd2);
      2:       return mk_step(TGT_PWR, 32'h0010_1700, 6'd0);
      3:       return mk_step(TGT_PWR, 32'h0010_1703, 6'd2);
      4:       return mk_step(TGT_CLK, 32'h0000_0001, 6'd0);
      5:       return mk_step(TGT_PWR, 32'h0010_1603, 6'd2);
      6:       return mk_step(TGT_OVR, 32'h0000_0000, 6'd0);
      7:       return mk_step(TGT_PWR, 32'h0010_0203, 6'd54);
      8:       return mk_step(TGT_PWR, 32'h1010_0203, 6'd0);
      default: return mk_step(TGT_CLK, 32'h0000_0003, 6'd0);
    endcase
  endfunction
endpackage

// File: rtl/l2_pwr_seq_timer.sv
module l2_pwr_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/l2_pwr_seq_regs.sv
module l2_pwr_seq_regs
  import l2_pwr_seq_pkg::*;
(
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [N_WORDS-1:0]              wr_en_i,
  input  logic [WORD_W-1:0]               wr_data_i,
  output logic [N_WORDS-1:0][WORD_W-1:0]  words_o
);
  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         q <= '0;
      else if (wr_en_i[g]) q <= wr_data_i;
    end
    assign words_o[g] = q;
  end
endmodule

// File: rtl/l2_pwr_seq_ctrl.sv
module l2_pwr_seq_ctrl
  import l2_pwr_seq_pkg::*;
#(
  parameter int CYC_PER_US = 100,
  parameter int CNT_W      = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               up_i,
  input  logic               tmr_zero_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [N_WORDS-1:0] wr_en_o,
  output logic [WORD_W-1:0]  wr_data_o,
  output logic               tmr_load_o,
  output logic [CNT_W-1:0]   tmr_val_o
);
  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_STEPS - 1);

  state_e           state_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  logic             fire;
  step_t            st;

  assign st   = step_at(idx_q);
  assign fire = (state_q == ST_RUN) && tmr_zero_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          if (up_i) begin
            done_q <= 1'b1;
          end else begin
            state_q <= ST_RUN;
            idx_q   <= '0;
          end
        end
        default: if (fire) begin
          if (idx_q == LAST_IDX) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
      endcase
    end
  end

  for (genvar g = 0; g < N_WORDS; g++) begin : g_en
    assign wr_en_o[g] = fire && (st.tgt == tgt_e'(g));
  end

  assign wr_data_o  = st.val;
  assign tmr_load_o = fire;
  assign tmr_val_o  = CNT_W'(32'(st.wait_us) * 32'(CYC_PER_US));
  assign busy_o     = (state_q == ST_RUN);
  assign done_o     = done_q;
endmodule

// File: rtl/l2_pwr_seq.sv
module l2_pwr_seq
  import l2_pwr_seq_pkg::*;
#(
  parameter int                CYC_PER_US = 100,
  parameter int                STAT_W     = 32,
  parameter logic [STAT_W-1:0] UP_MASK    = STAT_W'(1) << 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [STAT_W-1:0] status_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [31:0]       pwr_ctl_o,
  output logic [31:0]       ovr_ctl_o,
  output logic [31:0]       clk_ctl_o
);
  localparam int CNT_W = $clog2(MAX_WAIT_US * CYC_PER_US + 1);

  logic                           up;
  logic                           tmr_zero;
  logic                           tmr_load;
  logic [CNT_W-1:0]               tmr_val;
  logic [N_WORDS-1:0]             wr_en;
  logic [WORD_W-1:0]              wr_data;
  logic [N_WORDS-1:0][WORD_W-1:0] words;

  assign up = ((status_i & UP_MASK) == UP_MASK);

  l2_pwr_seq_ctrl #(.CYC_PER_US(CYC_PER_US), .CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .up_i       (up),
    .tmr_zero_i (tmr_zero),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val)
  );

  l2_pwr_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  l2_pwr_seq_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .words_o   (words)
  );

  assign pwr_ctl_o = words[TGT_PWR];
  assign ovr_ctl_o = words[TGT_OVR];
  assign clk_ctl_o = words[TGT_CLK];
endmodule

// File: rtl/l2_pwr_seq_chk.sv
module l2_pwr_seq_chk #(
  parameter int                STAT_W  = 32,
  parameter logic [STAT_W-1:0] UP_MASK = STAT_W'(1) << 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [STAT_W-1:0] status_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [31:0]       pwr_ctl_o,
  input logic [31:0]       ovr_ctl_o,
  input logic [31:0]       clk_ctl_o
);
  logic up;
  assign up = ((status_i & UP_MASK) == UP_MASK);

  p_reset_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pwr_ctl_o == '0 && ovr_ctl_o == '0 && clk_ctl_o == '0 && !busy_o && !done_o));

  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !up) |=> busy_o);

  p_busy_until_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));

  p_skip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && up) |=> (done_o && !busy_o));

  p_one_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({!$stable(pwr_ctl_o), !$stable(ovr_ctl_o), !$stable(clk_ctl_o)}) <= 1);

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> ($stable(pwr_ctl_o) && $stable(ovr_ctl_o) && $stable(clk_ctl_o)));
endmodule

bind l2_pwr_seq l2_pwr_seq_chk #(.STAT_W(STAT_W), .UP_MASK(UP_MASK)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .status_i  (status_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .pwr_ctl_o (pwr_ctl_o),
  .ovr_ctl_o (ovr_ctl_o),
  .clk_ctl_o (clk_ctl_o)
);

// File: tb/l2_pwr_seq_test.sv
`timescale 1ns/1ps
module l2_pwr_seq_test;
  localparam int          C      = 3;
  localparam logic [31:0] UPMASK = 32'h0000_0200;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] status_i = '0;
  logic        busy_o, done_o;
  logic [31:0] pwr_ctl_o, ovr_ctl_o, clk_ctl_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] m [3];

  always #2.5 clk_i = ~clk_i;

  l2_pwr_seq #(.CYC_PER_US(C), .STAT_W(32), .UP_MASK(UPMASK)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .status_i(status_i),
    .busy_o(busy_o), .done_o(done_o),
    .pwr_ctl_o(pwr_ctl_o), .ovr_ctl_o(ovr_ctl_o), .clk_ctl_o(clk_ctl_o)
  );

  // schedule restated from R4/R5: 0 power, 1 override, 2 clock
  function automatic int b_tgt(int k);
    case (k)
      1, 6:    return 1;
      4, 9:    return 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] b_val(int k);
    case (k)
      0: return 32'h0010_D700;
      1: return 32'h0040_0000;
      2: return 32'h0010_1700;
      3: return 32'h0010_1703;
      4: return 32'h0000_0001;
      5: return 32'h0010_1603;
      6: return 32'h0000_0000;
      7: return 32'h0010_0203;
      8: return 32'h1010_0203;
      default: return 32'h0000_0003;
    endcase
  endfunction

  function automatic int b_wait(int k);
    case (k)
      1, 3, 5: return 2;
      7:       return 54;
      default: return 0;
    endcase
  endfunction

  // cycles after the start edge at which write k becomes visible
  function automatic int b_time(int k);
    int t = k + 1;
    for (int j = 0; j < k; j++) t += C * b_wait(j);
    return t;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_words(input string req, input logic [31:0] e0, input logic [31:0] e1,
                           input logic [31:0] e2);
    chk(pwr_ctl_o == e0, {req, " power word"}, pwr_ctl_o, e0);
    chk(ovr_ctl_o == e1, {req, " override word"}, ovr_ctl_o, e1);
    chk(clk_ctl_o == e2, {req, " clock word"}, clk_ctl_o, e2);
  endtask

  task automatic run_full(input logic [31:0] st);
    logic [31:0] e [3];
    int tdone;
    e = m;
    tdone = b_time(9);
    @(negedge clk_i);
    start_i  = 1'b1;
    status_i = st & ~UPMASK;
    @(posedge clk_i);
    for (int t = 0; t <= tdone + 1; t++) begin
      @(negedge clk_i);
      for (int k = 0; k < 10; k++)
        if (b_time(k) == t) e[b_tgt(k)] = b_val(k);
      chk_words("R4 R5 R7", e[0], e[1], e[2]);
      chk(busy_o == (t < tdone), "R2 R7 busy", 32'(busy_o), 32'(t < tdone));
      chk(done_o == (t == tdone), "R6 done", 32'(done_o), 32'(t == tdone));
      if (t < tdone) begin
        start_i  = ($urandom % 3) == 0;  // stray starts while busy, R7
        status_i = $urandom;
      end else begin
        start_i  = 1'b0;
        status_i = $urandom & ~UPMASK;
      end
    end
    m = e;
  endtask

  task automatic run_skip(input logic [31:0] st);
    @(negedge clk_i);
    start_i  = 1'b1;
    status_i = st | UPMASK;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(done_o == 1'b1, "R3 skip done", 32'(done_o), 32'd1);
    chk(busy_o == 1'b0, "R3 skip busy", 32'(busy_o), 32'd0);
    chk_words("R3", m[0], m[1], m[2]);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk(done_o == 1'b0 && busy_o == 1'b0, "R6 R8 idle after skip", {30'd0, busy_o, done_o}, 32'd0);
      chk_words("R8 idle hold", m[0], m[1], m[2]);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c2e_5a17));
    m[0] = '0; m[1] = '0; m[2] = '0;
    repeat (3) @(negedge clk_i);
    chk_words("R1 reset", 32'd0, 32'd0, 32'd0);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1 reset flags", {30'd0, busy_o, done_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk_words("R8 idle before start", 32'd0, 32'd0, 32'd0);

    run_full($urandom);
    run_full(~UPMASK);          // R9: every other bit set
    run_skip(UPMASK);           // R3: mask bit only
    run_skip($urandom);
    run_full($urandom);

    for (int i = 0; i < 4; i++) begin
      if ($urandom % 2) run_skip($urandom);
      else              run_full($urandom);
    end

    // reset part way through a run, R1
    @(negedge clk_i);
    start_i  = 1'b1;
    status_i = '0;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (20) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk_words("R1 reset mid run", 32'd0, 32'd0, 32'd0);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1 reset mid run flags", {30'd0, busy_o, done_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    m[0] = '0; m[1] = '0; m[2] = '0;
    run_full($urandom);
    run_skip($urandom);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule